// File: doc/BRIEF.md
# Two-Dimensional Strided Address Sequencer

This block generates the word-address stream for one transfer direction of a frame-based DMA engine. A frame is a rectangle in memory. It has a number of lines, and each line is a run of consecutive bus-width words. A programmable gap of skipped words separates one line from the next. The block emits one byte address per beat on a valid/ready stream. A separate data mover consumes that stream and performs the bus accesses.

A start pulse launches a frame. The frame is launched at once, or, when sync is not disabled, only after an external frame-sync pulse arrives. The base address, line length, line count, gap and sync-disable flag are copied into the block when the start pulse is taken, so the register file can be rewritten while a frame is running. The loop flag is read live at the end of every frame. While it is set, the block starts the same frame again, waiting for frame sync first if that mode was chosen. Clearing the flag lets the running frame finish and then stops the block. A busy flag covers the whole transfer, and a one-clock done pulse marks the end of each frame.

Top module: `frame_addr_seq`

## Requirements
- R1: After synchronous reset, beat_valid_o, busy_o and done_o are all 0.
- R2: Beat k of a line has address base + (line_start_word + k) × (DATA_W/8), where DATA_W/8 is 4 bytes at the default width. Consecutive beats in a line therefore differ by DATA_W/8 bytes.
- R3: The first word of line n+1 lies line_len + gap words after the first word of line n. The first line starts at word 0.
- R4: While beat_valid_o is 1 and beat_ready_i is 0, beat_valid_o stays 1 and beat_addr_o holds its value into the next cycle.
- R5: busy_o rises in the cycle after a start pulse is taken from idle. In a non-looping frame it falls in the cycle after the last beat is accepted.
- R6: done_o is 1 for exactly the one cycle after the last beat of a frame is accepted.
- R7: With sync_dis_i at 0 when start is taken, no beat is presented until fsync_i is seen high. The first beat is valid in the cycle after that edge, and busy_o is 1 throughout the wait.
- R8: If loop_i is 1 at the end of a frame, the same frame restarts without a new start. It restarts at once when sync was disabled, and otherwise after the next fsync_i, with busy_o staying 1 meanwhile. If loop_i is 0 at the end of a frame, the block returns to idle.
- R9: Changes to base_addr_i, line_len_i, line_cnt_i, gap_i and sync_dis_i while busy_o is 1 do not alter the running frame or its loop repeats.
- R10: If line length or line count is 0 at launch, no beat is presented, busy_o stays 0 after the launch, and done_o pulses once in the cycle after the launch. This holds even when loop_i is 1.
- R11: start_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| sync_dis_i | input | 1 | 1: launch at once; 0: wait for fsync_i |
| loop_i | input | 1 | Restart the frame when it ends (read live) |
| fsync_i | input | 1 | External frame-sync event |
| base_addr_i | input | 32 | Byte address of the first word |
| line_len_i | input | 16 | Words per line |
| line_cnt_i | input | 16 | Lines per frame |
| gap_i | input | 16 | Words skipped between lines |
| beat_addr_o | output | 32 | Byte address of the current beat |
| beat_valid_o | output | 1 | Beat address is valid |
| beat_ready_i | input | 1 | Downstream accepts the beat |
| busy_o | output | 1 | Transfer in progress or armed |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A start pulse taken at one edge makes busy_o, and for an immediate launch also beat_valid_o, visible in the following cycle. An fsync_i taken at an edge makes the first beat valid in the following cycle. The done pulse and the fall of busy_o appear in the cycle after the edge that accepted the final beat. A zero-sized frame pulses done in the cycle after the start. The bench drives inputs just after rising edges and samples on falling edges. The timing checks are placed at exactly those cycles, and a scoreboard queue filled from the frame geometry is compared with every accepted beat, both under steady ready and under pseudo-random backpressure.

// File: rtl/fas_pkg.sv
package fas_pkg;

    localparam int unsigned FAS_ADDR_W = 32;
    localparam int unsigned FAS_CNT_W  = 16;

    typedef logic [FAS_ADDR_W-1:0] addr_t;
    typedef logic [FAS_CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // Frame geometry captured at launch
    typedef struct packed {
        addr_t base;
        cnt_t  words;
        cnt_t  lines;
        cnt_t  gap;
        logic  free_run;
    } frame_cfg_t;

    function automatic logic cfg_empty(input frame_cfg_t c);
        return (c.words == '0) || (c.lines == '0);
    endfunction

    // Word distance between the first words of consecutive lines
    function automatic addr_t line_step(input frame_cfg_t c);
        return addr_t'(c.words) + addr_t'(c.gap);
    endfunction

endpackage

// File: rtl/fas_cfg_hold.sv
module fas_cfg_hold
    import fas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  frame_cfg_t cfg_in,
    output frame_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/fas_ctrl.sv
module fas_ctrl
    import fas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       fsync_i,
    input  logic       loop_i,
    input  logic       free_run_now,
    input  logic       free_run_held,
    input  logic       empty_now,
    input  logic       frame_end,
    output seq_state_e state,
    output logic       capture,
    output logic       launch,
    output logic       done_o
);

    seq_state_e state_n;
    logic       done_n;
    logic       go_now;

    assign capture = (state == SEQ_IDLE) && start_i;

    // A launch happens from idle in immediate mode, or from armed on sync
    always_comb begin
        unique case (state)
            SEQ_IDLE:  go_now = start_i && free_run_now;
            SEQ_ARMED: go_now = fsync_i;
            default:   go_now = 1'b0;
        endcase
    end

    assign launch = go_now && !empty_now;

    always_comb begin
        state_n = state;
        done_n  = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (start_i) begin
                    if (!free_run_now) begin
                        state_n = SEQ_ARMED;
                    end else if (empty_now) begin
                        done_n = 1'b1;
                    end else begin
                        state_n = SEQ_RUN;
                    end
                end
            end
            SEQ_ARMED: begin
                if (fsync_i) begin
                    if (empty_now) begin
                        done_n  = 1'b1;
                        state_n = SEQ_IDLE;
                    end else begin
                        state_n = SEQ_RUN;
                    end
                end
            end
            SEQ_RUN: begin
                if (frame_end) begin
                    done_n = 1'b1;
                    if (!loop_i) begin
                        state_n = SEQ_IDLE;
                    end else if (!free_run_held) begin
                        state_n = SEQ_ARMED;
                    end
                end
            end
            default: state_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            done_o <= 1'b0;
        end else begin
            state  <= state_n;
            done_o <= done_n;
        end
    end

endmodule

// File: rtl/fas_walk.sv
module fas_walk
    import fas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       accept,
    input  frame_cfg_t cfg,
    output addr_t      word_off,
    output logic       frame_end
);

    cnt_t  col;
    cnt_t  row;
    addr_t line_base;
    logic  last_col;
    logic  last_row;
    addr_t next_line;

    assign last_col  = (col == cfg.words - 1'b1);
    assign last_row  = (row == cfg.lines - 1'b1);
    assign next_line = line_base + line_step(cfg);
    assign frame_end = accept && last_col && last_row;

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            col       <= '0;
            row       <= '0;
            line_base <= '0;
            word_off  <= '0;
        end else if (accept) begin
            if (!last_col) begin
                col      <= col + 1'b1;
                word_off <= word_off + 1'b1;
            end else if (!last_row) begin
                col       <= '0;
                row       <= row + 1'b1;
                line_base <= next_line;
                word_off  <= next_line;
            end else begin
                // frame wraps to its origin for a possible loop repeat
                col       <= '0;
                row       <= '0;
                line_base <= '0;
                word_off  <= '0;
            end
        end
    end

endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq
    import fas_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  sync_dis_i,
    input  logic                  loop_i,
    input  logic                  fsync_i,
    input  logic [FAS_ADDR_W-1:0] base_addr_i,
    input  logic [FAS_CNT_W-1:0]  line_len_i,
    input  logic [FAS_CNT_W-1:0]  line_cnt_i,
    input  logic [FAS_CNT_W-1:0]  gap_i,
    output logic [FAS_ADDR_W-1:0] beat_addr_o,
    output logic                  beat_valid_o,
    input  logic                  beat_ready_i,
    output logic                  busy_o,
    output logic                  done_o
);

    localparam int unsigned BYTES = DATA_W / 8;
    localparam int unsigned SHIFT = $clog2(BYTES);

    frame_cfg_t cfg_in;
    frame_cfg_t cfg_q;
    frame_cfg_t cfg_eff;
    seq_state_e state;
    logic       capture;
    logic       launch;
    logic       accept;
    logic       frame_end;
    addr_t      word_off;

    always_comb begin
        cfg_in.base     = base_addr_i;
        cfg_in.words    = line_len_i;
        cfg_in.lines    = line_cnt_i;
        cfg_in.gap      = gap_i;
        cfg_in.free_run = sync_dis_i;
    end

    // In idle the live inputs decide the launch, otherwise the held copy
    assign cfg_eff = (state == SEQ_IDLE) ? cfg_in : cfg_q;

    fas_cfg_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    fas_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .fsync_i       (fsync_i),
        .loop_i        (loop_i),
        .free_run_now  (cfg_in.free_run),
        .free_run_held (cfg_q.free_run),
        .empty_now     (cfg_empty(cfg_eff)),
        .frame_end     (frame_end),
        .state         (state),
        .capture       (capture),
        .launch        (launch),
        .done_o        (done_o)
    );

    fas_walk u_walk (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .accept    (accept),
        .cfg       (cfg_q),
        .word_off  (word_off),
        .frame_end (frame_end)
    );

    assign beat_valid_o = (state == SEQ_RUN);
    assign accept       = beat_valid_o && beat_ready_i;
    assign busy_o       = (state != SEQ_IDLE);
    assign beat_addr_o  = cfg_q.base + (word_off << SHIFT);

endmodule

// File: rtl/frame_addr_seq_chk.sv
module frame_addr_seq_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [AW-1:0] beat_addr_o,
    input logic          beat_valid_o,
    input logic          beat_ready_i,
    input logic          busy_o,
    input logic          done_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !beat_valid_o && !done_o));

    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_addr_o)));

    // R5
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o |-> busy_o);

    // R11
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) || $past(start_i)));

endmodule

bind frame_addr_seq frame_addr_seq_chk #(.AW(fas_pkg::FAS_ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .beat_addr_o  (beat_addr_o),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/frame_addr_seq_test.sv
module frame_addr_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        sync_dis_i = 1'b1;
    logic        loop_i = 1'b0;
    logic        fsync_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [15:0] line_len_i = '0;
    logic [15:0] line_cnt_i = '0;
    logic [15:0] gap_i = '0;
    logic [31:0] beat_addr_o;
    logic        beat_valid_o;
    logic        beat_ready_i;
    logic        busy_o;
    logic        done_o;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_q[$];
    logic        bp_mode = 1'b0;
    logic [7:0]  lfsr = 8'h5a;

    always #2 clk = ~clk;

    frame_addr_seq uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .sync_dis_i   (sync_dis_i),
        .loop_i       (loop_i),
        .fsync_i      (fsync_i),
        .base_addr_i  (base_addr_i),
        .line_len_i   (line_len_i),
        .line_cnt_i   (line_cnt_i),
        .gap_i        (gap_i),
        .beat_addr_o  (beat_addr_o),
        .beat_valid_o (beat_valid_o),
        .beat_ready_i (beat_ready_i),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    assign beat_ready_i = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;

    always begin
        @(posedge clk);
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare accepted beats with the scoreboard, check holds
    logic        was_stalled = 1'b0;
    logic [31:0] stall_addr = '0;
    always @(negedge clk) begin
        logic [31:0] e;
        if (!rst) begin
            if (was_stalled) begin
                check("R4 valid held", {31'd0, beat_valid_o}, 32'd1);
                check("R4 addr held", beat_addr_o, stall_addr);
            end
            if (beat_valid_o && beat_ready_i) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected beat", beat_addr_o, 32'hffff_ffff);
                end else begin
                    e = exp_q.pop_front();
                    check("R2/R3 beat address", beat_addr_o, e);
                end
            end
            was_stalled = beat_valid_o && !beat_ready_i;
            stall_addr  = beat_addr_o;
        end
    end

    task automatic push_frame(input logic [31:0] base, input int len, input int cnt, input int gap);
        for (int l = 0; l < cnt; l++) begin
            for (int w = 0; w < len; w++) begin
                exp_q.push_back(base + 32'((l * (len + gap) + w) * 4));
            end
        end
    endtask

    task automatic start_frame(input logic [31:0] base, input int len, input int cnt, input int gap,
                               input logic sd, input logic lp);
        @(posedge clk); #1;
        base_addr_i = base;
        line_len_i  = 16'(len);
        line_cnt_i  = 16'(cnt);
        gap_i       = 16'(gap);
        sync_dis_i  = sd;
        loop_i      = lp;
        start_i     = 1'b1;
        @(posedge clk); #1;
        start_i     = 1'b0;
    endtask

    task automatic pulse_sync();
        @(posedge clk); #1;
        fsync_i = 1'b1;
        @(posedge clk); #1;
        fsync_i = 1'b0;
    endtask

    // Returns on the falling edge where done_o is seen high
    task automatic wait_done(input string req);
        int t;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!done_o && t < 2000);
        check(req, {31'd0, done_o}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy_o}, 32'd0);
        check("R1 valid", {31'd0, beat_valid_o}, 32'd0);
        check("R1 done", {31'd0, done_o}, 32'd0);

        // R2 R3 R5 R6: immediate frame, ready always high
        push_frame(32'h1000, 3, 2, 2);
        start_frame(32'h1000, 3, 2, 2, 1'b1, 1'b0);
        @(negedge clk);
        check("R5 busy after start", {31'd0, busy_o}, 32'd1);
        wait_done("R6 done seen");
        check("R5 busy low at done", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        check("R6 done one cycle", {31'd0, done_o}, 32'd0);
        check("R3 frame drained", 32'(exp_q.size()), 32'd0);

        // R4: backpressure, gap zero
        bp_mode = 1'b1;
        push_frame(32'h2000, 4, 3, 0);
        start_frame(32'h2000, 4, 3, 0, 1'b1, 1'b0);
        wait_done("R4 done under backpressure");
        check("R4 frame drained", 32'(exp_q.size()), 32'd0);

        // R9 R11: inputs rewritten and start re-pulsed while busy
        push_frame(32'h3000, 2, 3, 5);
        start_frame(32'h3000, 2, 3, 5, 1'b1, 1'b0);
        base_addr_i = 32'h9000;
        line_len_i  = 16'd7;
        line_cnt_i  = 16'd1;
        gap_i       = 16'd1;
        start_i     = 1'b1;
        @(posedge clk); #1;
        start_i     = 1'b0;
        wait_done("R9 done");
        repeat (10) @(negedge clk);
        check("R11 no extra beats", {31'd0, beat_valid_o}, 32'd0);
        check("R9 R11 queue empty", 32'(exp_q.size()), 32'd0);
        bp_mode = 1'b0;

        // R7: wait for frame sync
        push_frame(32'h4000, 2, 2, 1);
        start_frame(32'h4000, 2, 2, 1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check("R7 no beat before sync", {31'd0, beat_valid_o}, 32'd0);
        check("R7 busy while armed", {31'd0, busy_o}, 32'd1);
        pulse_sync();
        @(negedge clk);
        check("R7 valid after sync", {31'd0, beat_valid_o}, 32'd1);
        wait_done("R7 done");

        // R8: loop immediate, three frames then stop
        push_frame(32'h5000, 2, 2, 1);
        push_frame(32'h5000, 2, 2, 1);
        push_frame(32'h5000, 2, 2, 1);
        start_frame(32'h5000, 2, 2, 1, 1'b1, 1'b1);
        wait_done("R8 loop done 1");
        check("R8 busy kept", {31'd0, busy_o}, 32'd1);
        wait_done("R8 loop done 2");
        @(posedge clk); #1;
        loop_i = 1'b0;
        wait_done("R8 loop done 3");
        check("R8 idle after loop clear", {31'd0, busy_o}, 32'd0);
        check("R8 three frames", 32'(exp_q.size()), 32'd0);

        // R8: loop with sync waits again for sync
        push_frame(32'h6000, 1, 1, 0);
        push_frame(32'h6000, 1, 1, 0);
        start_frame(32'h6000, 1, 1, 0, 1'b0, 1'b1);
        pulse_sync();
        wait_done("R8 sync loop done 1");
        @(negedge clk);
        check("R8 rearmed no beat", {31'd0, beat_valid_o}, 32'd0);
        check("R8 rearmed busy", {31'd0, busy_o}, 32'd1);
        @(posedge clk); #1;
        loop_i = 1'b0;
        pulse_sync();
        wait_done("R8 sync loop done 2");
        check("R8 sync loop drained", 32'(exp_q.size()), 32'd0);

        // R10: zero length, looping
        start_frame(32'h7000, 0, 3, 0, 1'b1, 1'b1);
        @(negedge clk);
        check("R10 done on zero length", {31'd0, done_o}, 32'd1);
        check("R10 busy low", {31'd0, busy_o}, 32'd0);
        check("R10 no valid", {31'd0, beat_valid_o}, 32'd0);
        @(negedge clk);
        check("R10 single done", {31'd0, done_o}, 32'd0);
        loop_i = 1'b0;

        // R10: zero count after sync
        start_frame(32'h7000, 4, 0, 0, 1'b0, 1'b0);
        pulse_sync();
        @(negedge clk);
        check("R10 done on zero count", {31'd0, done_o}, 32'd1);
        check("R10 idle after zero count", {31'd0, busy_o}, 32'd0);
        repeat (4) @(negedge clk);
        check("R10 nothing issued", 32'(exp_q.size()), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule